// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block is a single-channel transmit DMA engine. Software builds a singly linked list of buffer descriptors in memory and starts the engine by writing the address of the first descriptor into the head register. The engine then walks the list. It reads each descriptor over a synchronous memory port and streams the referenced buffer bytes, one per strobe, onto a byte-wide output that carries packet start and end markers.

A packet is a run of descriptors that ends at one whose end-of-packet flag is set. When a packet is finished, the engine hands the descriptors back by writing their flag words in a fixed order. It then publishes the address of the packet's last descriptor as a one-cycle completion strobe, which serves as the interrupt. When the list runs out, the engine also marks end of queue and clears the head register. At that point software may start a new list.

The engine rejects bad head writes and reports them on an error code output. A write made while the head register is nonzero is rejected, and so is a write of a misaligned address. The engine also stops with an error when the first descriptor of a packet is not owned by hardware.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `hdp_o` is zero, `tx_valid_o`, `tx_sop_o`, `tx_eop_o`, `cmpl_we_o` and `mem_req_o` are low, and `err_code_o` is 0 (no error).
- R2: A host write of a nonzero address with bits [1:0] zero is accepted while `hdp_o` is zero. It loads `hdp_o` on the next cycle and starts a list walk. Each descriptor is four words at consecutive word addresses. Word 0 is the next pointer (zero ends the list) and word 1 is the buffer byte address. Word 2 holds the offset in [31:16] and the length in bytes in [15:0]. Word 3 holds the flags: bit 31 start-of-packet, bit 30 end-of-packet, bit 29 owned-by-hardware and bit 28 end-of-queue.
- R3: Buffer bytes leave in list order, one per `tx_valid_o` strobe. The byte at address a is taken from bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a with bits [1:0] cleared. `tx_sop_o` marks the first byte of a packet. `tx_eop_o` marks the last byte of the buffer of the descriptor whose end-of-packet flag is set.
- R4: The buffer offset is added to the buffer address only on a descriptor whose start-of-packet flag is set. On any other descriptor it has no effect on the bytes sent.
- R5: When the first descriptor of a packet has its owned flag clear, no byte is sent and nothing is written to memory. `err_code_o` becomes 1, `hdp_o` returns to zero, and no completion strobe follows.
- R6: A host write while `hdp_o` is nonzero is ignored: `hdp_o` and the byte stream are unchanged, and `err_code_o` becomes 2.
- R7: A host write of a nonzero address with bits [1:0] not zero is ignored. `hdp_o` stays zero and `err_code_o` becomes 3.
- R8: At the end of a packet that is not the last in the list, the engine writes the flags word of that packet's start descriptor with the owned bit cleared. It then pulses the completion strobe with the address of the packet's end descriptor. The end descriptor's flags word is not written.
- R9: At the end of the last packet, four steps follow in this order. First the end descriptor's flags word is written with end-of-queue set. Next the start descriptor's flags word is written with the owned bit cleared, then `hdp_o` goes to zero, and last the completion strobe fires.
- R10: When one descriptor is both the start and the end of the last packet, its final flags word keeps end-of-queue set and has the owned bit clear.
- R11: An accepted head write sets `err_code_o` back to 0.
- R12: `cmpl_we_o` is a single-cycle pulse, with `cmpl_ptr_o` carrying the completed packet's end-descriptor address in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdp_we_i | input | 1 | Host write strobe for the head register |
| hdp_wdata_i | input | 32 | Host write data (descriptor address) |
| hdp_o | output | 32 | Current head register value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable (read when low) |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |
| tx_valid_o | output | 1 | Byte strobe |
| tx_data_o | output | 8 | Byte data |
| tx_sop_o | output | 1 | First byte of packet |
| tx_eop_o | output | 1 | Last byte of packet |
| cmpl_we_o | output | 1 | Completion strobe (interrupt) |
| cmpl_ptr_o | output | 32 | Completed packet's end-descriptor address |
| err_code_o | output | 2 | 0 none, 1 start descriptor not owned, 2 head write while active, 3 misaligned head |

## Verification
A bad state in the list walker shows up at the ports as a wrong, missing or extra byte in the stream. It can also show up as a flags write-back that is out of order or has the wrong value, or as a completion at the wrong address. The scoreboard flags each of these at the first strobe or memory write where it appears. A broken head-register guard appears in the cycle after the host write, either as a changed `hdp_o` or as a wrong error code. A dropped end-of-queue bit on a single-descriptor packet is caught when the final flags word is read back from the bench memory.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LEN_W   = 16;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned FLAG_OFS   = (DESC_WORDS - 1) * (DATA_W / 8);

  localparam int unsigned FL_SOP = 31;
  localparam int unsigned FL_EOP = 30;
  localparam int unsigned FL_OWN = 29;
  localparam int unsigned FL_EOQ = 28;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_SOP_UNOWNED = 2'd1,
    ERR_HEAD_BUSY   = 2'd2,
    ERR_HEAD_ALIGN  = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_FCAP, ST_CHECK, ST_BREQ, ST_BCAP,
    ST_DDONE, ST_WR_EOQ, ST_WR_OWN, ST_ZERO, ST_CMPL
  } walk_st_e;
endpackage

// File: rtl/txdesc_head_reg.sv
module txdesc_head_reg
  import txdesc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              own_err_i,
  output logic [ADDR_W-1:0] head_o,
  output err_e              err_o
);
  logic [ADDR_W-1:0] head_q;
  err_e              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      err_q  <= ERR_NONE;
    end else begin
      if (clr_i)     head_q <= '0;
      if (own_err_i) err_q  <= ERR_SOP_UNOWNED;
      // host rejection overrides engine error in the same cycle
      if (we_i) begin
        if (head_q != '0)            err_q <= ERR_HEAD_BUSY;
        else if (wdata_i[1:0] != 2'b00) err_q <= ERR_HEAD_ALIGN;
        else if (wdata_i != '0) begin
          head_q <= wdata_i;
          err_q  <= ERR_NONE;
        end
      end
    end
  end

  assign head_o = head_q;
  assign err_o  = err_q;
endmodule

// File: rtl/txdesc_byte_lane.sv
module txdesc_byte_lane
  import txdesc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              sop_o,
  output logic              eop_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
    end else begin
      valid_o <= ld_i;
      sop_o   <= ld_i & sop_i;
      eop_o   <= ld_i & eop_i;
      if (ld_i) data_o <= lanes[lane_i];
    end
  end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txdesc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] head_i,
  output logic              head_clr_o,
  output logic              own_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              byte_ld_o,
  output logic [LANE_W-1:0] byte_lane_o,
  output logic              byte_sop_o,
  output logic              byte_eop_o,
  output logic              cmpl_we_o,
  output logic [ADDR_W-1:0] cmpl_ptr_o
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  walk_st_e          st_q;
  logic [IDX_W-1:0]  widx_q;
  logic [DATA_W-1:0] dw_q [DESC_WORDS];
  logic [ADDR_W-1:0] cur_q, sop_addr_q, baddr_q;
  logic [DATA_W-1:0] sop_flags_q;
  logic [LEN_W-1:0]  rem_q;
  logic              first_q, first_byte_q, end_q;

  logic [ADDR_W-1:0] nxt;
  logic [LEN_W-1:0]  d_len, d_off;
  logic [DATA_W-1:0] d_flags;
  assign nxt     = dw_q[0];
  assign d_off   = dw_q[2][DATA_W-1 -: LEN_W];
  assign d_len   = dw_q[2][LEN_W-1:0];
  assign d_flags = dw_q[3];

  logic [DATA_W-1:0] eoq_bit, own_bit;
  assign eoq_bit = DATA_W'(1) << FL_EOQ;
  assign own_bit = DATA_W'(1) << FL_OWN;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    head_clr_o  = 1'b0;
    own_err_o   = 1'b0;
    byte_ld_o   = 1'b0;
    byte_lane_o = baddr_q[LANE_W-1:0];
    byte_sop_o  = first_byte_q;
    byte_eop_o  = d_flags[FL_EOP] && (rem_q == LEN_W'(1));
    unique case (st_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + ADDR_W'({widx_q, 2'b00});
      end
      ST_CHECK: if (first_q && !d_flags[FL_OWN]) begin
        own_err_o  = 1'b1;
        head_clr_o = 1'b1;
      end
      ST_BREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {baddr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
      end
      ST_BCAP: byte_ld_o = 1'b1;
      ST_WR_EOQ: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(FLAG_OFS);
        mem_wdata_o = d_flags | eoq_bit;
      end
      ST_WR_OWN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sop_addr_q + ADDR_W'(FLAG_OFS);
        // keep EOQ when start and end descriptor coincide
        mem_wdata_o = (sop_flags_q & ~own_bit)
                    | ((end_q && sop_addr_q == cur_q) ? eoq_bit : '0);
      end
      ST_ZERO: head_clr_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      widx_q       <= '0;
      for (int i = 0; i < DESC_WORDS; i++) dw_q[i] <= '0;
      cur_q        <= '0;
      sop_addr_q   <= '0;
      sop_flags_q  <= '0;
      baddr_q      <= '0;
      rem_q        <= '0;
      first_q      <= 1'b0;
      first_byte_q <= 1'b0;
      end_q        <= 1'b0;
      cmpl_we_o    <= 1'b0;
      cmpl_ptr_o   <= '0;
    end else begin
      cmpl_we_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (head_i != '0) begin
          cur_q        <= head_i;
          first_q      <= 1'b1;
          first_byte_q <= 1'b1;
          widx_q       <= '0;
          st_q         <= ST_FETCH;
        end
        ST_FETCH: st_q <= ST_FCAP;
        ST_FCAP: begin
          dw_q[widx_q] <= mem_rdata_i;
          if (widx_q == IDX_W'(DESC_WORDS - 1)) st_q <= ST_CHECK;
          else begin
            widx_q <= widx_q + 1'b1;
            st_q   <= ST_FETCH;
          end
        end
        ST_CHECK: begin
          if (first_q && !d_flags[FL_OWN]) st_q <= ST_IDLE;
          else begin
            if (first_q) begin
              sop_addr_q  <= cur_q;
              sop_flags_q <= d_flags;
            end
            baddr_q <= dw_q[1] + (d_flags[FL_SOP] ? ADDR_W'(d_off) : '0);
            rem_q   <= d_len;
            st_q    <= (d_len == '0) ? ST_DDONE : ST_BREQ;
          end
        end
        ST_BREQ: st_q <= ST_BCAP;
        ST_BCAP: begin
          first_byte_q <= 1'b0;
          baddr_q      <= baddr_q + 1'b1;
          rem_q        <= rem_q - 1'b1;
          st_q         <= (rem_q == LEN_W'(1)) ? ST_DDONE : ST_BREQ;
        end
        ST_DDONE: begin
          end_q <= (nxt == '0);
          if (d_flags[FL_EOP] || nxt == '0)
            st_q <= (nxt == '0) ? ST_WR_EOQ : ST_WR_OWN;
          else begin
            cur_q   <= nxt;
            first_q <= 1'b0;
            widx_q  <= '0;
            st_q    <= ST_FETCH;
          end
        end
        ST_WR_EOQ: st_q <= ST_WR_OWN;
        ST_WR_OWN: st_q <= end_q ? ST_ZERO : ST_CMPL;
        ST_ZERO:   st_q <= ST_CMPL;
        ST_CMPL: begin
          cmpl_we_o  <= 1'b1;
          cmpl_ptr_o <= cur_q;
          if (end_q) st_q <= ST_IDLE;
          else begin
            cur_q        <= nxt;
            first_q      <= 1'b1;
            first_byte_q <= 1'b1;
            widx_q       <= '0;
            st_q         <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txdesc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdp_we_i,
  input  logic [ADDR_W-1:0] hdp_wdata_i,
  output logic [ADDR_W-1:0] hdp_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  output logic              cmpl_we_o,
  output logic [ADDR_W-1:0] cmpl_ptr_o,
  output logic [1:0]        err_code_o
);
  logic              head_clr, own_err;
  logic              byte_ld, byte_sop, byte_eop;
  logic [LANE_W-1:0] byte_lane;
  err_e              err;

  txdesc_head_reg i_head (
    .clk_i, .rst_ni,
    .we_i      (hdp_we_i),
    .wdata_i   (hdp_wdata_i),
    .clr_i     (head_clr),
    .own_err_i (own_err),
    .head_o    (hdp_o),
    .err_o     (err)
  );

  txdesc_walker i_walk (
    .clk_i, .rst_ni,
    .head_i      (hdp_o),
    .head_clr_o  (head_clr),
    .own_err_o   (own_err),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .byte_ld_o   (byte_ld),
    .byte_lane_o (byte_lane),
    .byte_sop_o  (byte_sop),
    .byte_eop_o  (byte_eop),
    .cmpl_we_o, .cmpl_ptr_o
  );

  txdesc_byte_lane i_lane (
    .clk_i, .rst_ni,
    .ld_i    (byte_ld),
    .word_i  (mem_rdata_i),
    .lane_i  (byte_lane),
    .sop_i   (byte_sop),
    .eop_i   (byte_eop),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o),
    .sop_o   (tx_sop_o),
    .eop_o   (tx_eop_o)
  );

  assign err_code_o = err;
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hdp_we_i,
  input logic [31:0] hdp_wdata_i,
  input logic [31:0] hdp_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        tx_valid_o,
  input logic        tx_sop_o,
  input logic        tx_eop_o,
  input logic        cmpl_we_o,
  input logic [1:0]  err_code_o
);
  p_head_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdp_we_i && hdp_o == 32'd0 && hdp_wdata_i != 32'd0 && hdp_wdata_i[1:0] == 2'b00)
    |=> (hdp_o == $past(hdp_wdata_i) && err_code_o == 2'd0));

  p_head_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdp_o[1:0] == 2'b00);

  p_markers_qualified_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> (!tx_sop_o && !tx_eop_o));

  p_busy_write_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdp_we_i && hdp_o != 32'd0)
    |=> (err_code_o == 2'd2 && (hdp_o == $past(hdp_o) || hdp_o == 32'd0)));

  p_misaligned_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdp_we_i && hdp_o == 32'd0 && hdp_wdata_i[1:0] != 2'b00)
    |=> (err_code_o == 2'd3 && hdp_o == 32'd0));

  p_write_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_addr_o[1:0] == 2'b00));

  p_stream_under_head_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> hdp_o != 32'd0);

  p_cmpl_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_we_o |=> !cmpl_we_o);
endmodule

bind txdesc_dma txdesc_dma_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hdp_we_i(hdp_we_i), .hdp_wdata_i(hdp_wdata_i),
  .hdp_o(hdp_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .tx_valid_o(tx_valid_o), .tx_sop_o(tx_sop_o), .tx_eop_o(tx_eop_o),
  .cmpl_we_o(cmpl_we_o), .err_code_o(err_code_o)
);

// File: tb/test_txdesc_dma.sv
`timescale 1ns/1ps
module test_txdesc_dma;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hdp_we_i = 1'b0;
  logic [31:0] hdp_wdata_i = '0;
  logic [31:0] hdp_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        tx_valid_o, tx_sop_o, tx_eop_o;
  logic [7:0]  tx_data_o;
  logic        cmpl_we_o;
  logic [31:0] cmpl_ptr_o;
  logic [1:0]  err_code_o;

  localparam logic [31:0] F_SOP = 32'h8000_0000;
  localparam logic [31:0] F_EOP = 32'h4000_0000;
  localparam logic [31:0] F_OWN = 32'h2000_0000;
  localparam logic [31:0] F_EOQ = 32'h1000_0000;
  localparam logic [1:0]  K_WR = 2'd0, K_ZERO = 2'd1, K_CMPL = 2'd2;

  always #4 clk_i = ~clk_i;

  txdesc_dma i_txdesc_dma (.*);

  logic [31:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
    else if (mem_req_o)        mem_rdata_i <= mem[mem_addr_o[9:2]];
  end

  int n_chk = 0, n_bad = 0;
  logic [9:0]  q_byte [$];
  logic [65:0] q_ev [$];
  logic [31:0] prev_hdp = '0;

  function automatic logic [7:0] bval(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] bp,
                          input logic [15:0] off, input logic [15:0] len, input logic [31:0] fl);
    mem[base/4]     = nxt;
    mem[base/4 + 1] = bp;
    mem[base/4 + 2] = {off, len};
    mem[base/4 + 3] = fl;
  endtask

  task automatic exp_bytes(input logic [31:0] start, input int len, input logic sop, input logic eop);
    for (int k = 0; k < len; k++) begin
      logic [31:0] a;
      a = start + k;
      q_byte.push_back({sop && k == 0, eop && k == len - 1, bval(a)});
    end
  endtask

  task automatic exp_ev(input logic [1:0] kind, input logic [31:0] a, input logic [31:0] d);
    q_ev.push_back({kind, a, d});
  endtask

  task automatic host_write(input logic [31:0] v);
    @(negedge clk_i);
    hdp_we_i = 1'b1;
    hdp_wdata_i = v;
    @(negedge clk_i);
    hdp_we_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (q_byte.size() == 0 && q_ev.size() == 0) break;
    end
    repeat (4) @(negedge clk_i);
    check(q_byte.size() == 0 && q_ev.size() == 0, "R9 queues drained",
          32'(q_byte.size() + q_ev.size()), 32'd0);
  endtask

  // monitor: compares stream bytes and ordered write-back events
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tx_valid_o) begin
        if (q_byte.size() == 0) check(1'b0, "R3 unexpected byte", {22'd0, tx_sop_o, tx_eop_o, tx_data_o}, 32'd0);
        else begin
          logic [9:0] e;
          e = q_byte.pop_front();
          check({tx_sop_o, tx_eop_o, tx_data_o} == e, "R3/R4 byte+markers",
                {22'd0, tx_sop_o, tx_eop_o, tx_data_o}, {22'd0, e});
        end
      end
      if (mem_req_o && mem_we_o) begin
        if (q_ev.size() == 0) check(1'b0, "R5/R8 unexpected write", mem_addr_o, 32'd0);
        else begin
          logic [65:0] e;
          e = q_ev.pop_front();
          check(e[65:64] == K_WR && e[63:32] == mem_addr_o, "R9 write order/addr", mem_addr_o, e[63:32]);
          check(e[31:0] == mem_wdata_o, "R8/R9 write data", mem_wdata_o, e[31:0]);
        end
      end
      if (prev_hdp != 32'd0 && hdp_o == 32'd0) begin
        if (q_ev.size() == 0) check(1'b0, "R9 unexpected head zero", 32'd0, 32'd1);
        else begin
          logic [65:0] e;
          e = q_ev.pop_front();
          check(e[65:64] == K_ZERO, "R9 head zero order", {30'd0, e[65:64]}, {30'd0, K_ZERO});
        end
      end
      if (cmpl_we_o) begin
        if (q_ev.size() == 0) check(1'b0, "R12 unexpected completion", cmpl_ptr_o, 32'd0);
        else begin
          logic [65:0] e;
          e = q_ev.pop_front();
          check(e[65:64] == K_CMPL && e[63:32] == cmpl_ptr_o, "R12 completion ptr", cmpl_ptr_o, e[63:32]);
        end
      end
      prev_hdp = hdp_o;
    end
  end

  logic done = 1'b0;

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] = {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)};
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(hdp_o == 0, "R1 head", hdp_o, 0);
    check(!tx_valid_o && !tx_sop_o && !tx_eop_o, "R1 stream", {29'd0, tx_valid_o, tx_sop_o, tx_eop_o}, 0);
    check(!cmpl_we_o && !mem_req_o, "R1 strobes", {30'd0, cmpl_we_o, mem_req_o}, 0);
    check(err_code_o == 0, "R1 err", {30'd0, err_code_o}, 0);
    rst_ni = 1'b1;

    // R2 R3 R9 R10: single-descriptor packet with offset
    put_desc(32'h100, 0, 32'h300, 16'd1, 16'd5, F_SOP | F_EOP | F_OWN);
    exp_bytes(32'h301, 5, 1'b1, 1'b1);
    exp_ev(K_WR, 32'h10C, F_SOP | F_EOP | F_OWN | F_EOQ);
    exp_ev(K_WR, 32'h10C, F_SOP | F_EOP | F_EOQ);
    exp_ev(K_ZERO, 0, 0);
    exp_ev(K_CMPL, 32'h100, 0);
    host_write(32'h100);
    check(hdp_o == 32'h100, "R2 head loaded", hdp_o, 32'h100);
    drain();
    check(mem[32'h10C/4] == (F_SOP | F_EOP | F_EOQ), "R10 final flags", mem[32'h10C/4], F_SOP | F_EOP | F_EOQ);
    check(hdp_o == 0 && err_code_o == 0, "R9 idle after queue", {hdp_o[29:0], err_code_o}, 0);

    // R4 R6 R8: two packets, three descriptors, busy write mid-stream
    put_desc(32'h140, 32'h160, 32'h320, 16'd2, 16'd3, F_SOP | F_OWN);
    put_desc(32'h160, 32'h180, 32'h340, 16'd7, 16'd4, F_EOP);
    put_desc(32'h180, 0, 32'h360, 16'd0, 16'd2, F_SOP | F_EOP | F_OWN);
    exp_bytes(32'h322, 3, 1'b1, 1'b0);
    exp_bytes(32'h340, 4, 1'b0, 1'b1);
    exp_bytes(32'h360, 2, 1'b1, 1'b1);
    exp_ev(K_WR, 32'h14C, F_SOP);
    exp_ev(K_CMPL, 32'h160, 0);
    exp_ev(K_WR, 32'h18C, F_SOP | F_EOP | F_OWN | F_EOQ);
    exp_ev(K_WR, 32'h18C, F_SOP | F_EOP | F_EOQ);
    exp_ev(K_ZERO, 0, 0);
    exp_ev(K_CMPL, 32'h180, 0);
    host_write(32'h140);
    repeat (12) @(negedge clk_i);
    host_write(32'h200);
    check(err_code_o == 2'd2, "R6 busy err", {30'd0, err_code_o}, 2);
    check(hdp_o == 32'h140, "R6 head kept", hdp_o, 32'h140);
    drain();
    check(mem[32'h16C/4] == F_EOP, "R8 end desc untouched", mem[32'h16C/4], F_EOP);

    // R7 misaligned
    host_write(32'h202);
    check(err_code_o == 2'd3 && hdp_o == 0, "R7 misaligned", {hdp_o[29:0], err_code_o}, 3);

    // R5 R11 unowned start descriptor
    put_desc(32'h1C0, 0, 32'h380, 16'd0, 16'd3, F_SOP | F_EOP);
    exp_ev(K_ZERO, 0, 0);
    host_write(32'h1C0);
    check(err_code_o == 0 && hdp_o == 32'h1C0, "R11 err cleared", {hdp_o[29:0], err_code_o}, 32'h700);
    repeat (40) @(negedge clk_i);
    check(err_code_o == 2'd1, "R5 err code", {30'd0, err_code_o}, 1);
    check(hdp_o == 0 && q_ev.size() == 0, "R5 head zero", hdp_o, 0);
    check(mem[32'h1CC/4] == (F_SOP | F_EOP), "R5 no write-back", mem[32'h1CC/4], F_SOP | F_EOP);

    // R11 recovery run
    put_desc(32'h100, 0, 32'h3A0, 16'd3, 16'd6, F_SOP | F_EOP | F_OWN);
    exp_bytes(32'h3A3, 6, 1'b1, 1'b1);
    exp_ev(K_WR, 32'h10C, F_SOP | F_EOP | F_OWN | F_EOQ);
    exp_ev(K_WR, 32'h10C, F_SOP | F_EOP | F_EOQ);
    exp_ev(K_ZERO, 0, 0);
    exp_ev(K_CMPL, 32'h100, 0);
    host_write(32'h100);
    check(err_code_o == 0, "R11 err cleared again", {30'd0, err_code_o}, 0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule